// File: doc/BRIEF.md
# Status Register Write Guard

This block keeps the protection state of a serial memory: a status byte with a register-lock bit, two region-select bits, a write-enable latch and a busy bit. It receives decoded command strobes from an instruction decoder: enable, disable, status write and array write. An array write comes with its start address and a status write with its data byte. The block also takes the level of the write-protect pin and a pulse that marks the end of a self-timed programming cycle.

For every array or status write it decides in the same cycle whether the operation may start. It grants the write only when the enable latch is set, the device is not busy, and the target is not protected. The status byte is always present on an output for a status read. The busy flag stays high from an accepted write until the programming-done pulse.

Region protection covers a 16-bit address space. The two region-select bits select no protection, the top quarter, the top half or the whole array. Status writes can be locked by hardware. This happens when the lock bit is set and the write-protect pin is driven low.

Top module: `sreg_guard`

## Requirements
- R1: After synchronous reset the status byte reads 0x00, `busy_o` is 0, and `grant_o` and `deny_o` are 0 while no command is presented.
- R2: The status byte carries the lock bit at bit 7, the region-select pair at bits 3:2, the enable latch at bit 1 and the busy bit at bit 0. Bits 6:4 always read 0.
- R3: While not busy, an enable strobe sets the enable latch from the next cycle on. A disable strobe clears it from the next cycle on.
- R4: An array or status write presented while the enable latch is 0 is denied, and the status byte does not change.
- R5: An array write is denied when its start address lies in the protected region. Region-select 00 protects no address, 01 protects 0xC000 to 0xFFFF, 10 protects 0x8000 to 0xFFFF, and 11 protects every address. Otherwise, with the latch set and the block idle, the write is granted.
- R6: A status write is denied when the lock bit is 1 and `wp_level_i` is 0. When the lock bit is 0, or `wp_level_i` is 1, it is granted if the latch is set and the block is idle.
- R7: A granted write sets the busy bit from the next cycle on. `busy_o` always equals status bit 0.
- R8: A `prog_done_i` pulse while busy clears both the busy bit and the enable latch in the next cycle. A pulse while idle has no effect.
- R9: While busy, every array or status write is denied, and enable and disable strobes leave the enable latch unchanged.
- R10: A denied array write leaves the enable latch as it was.
- R11: A granted status write loads the lock bit from data bit 7 and the region-select pair from data bits 3:2, visible from the next cycle. All other data bits are ignored.
- R12: In every cycle at most one of `grant_o` and `deny_o` is high. One of them is high exactly when an array or status write strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wren_i | input | 1 | Write-enable strobe |
| cmd_wrdi_i | input | 1 | Write-disable strobe |
| cmd_wrsr_i | input | 1 | Status write strobe |
| cmd_write_i | input | 1 | Array write strobe |
| wr_addr_i | input | 16 | Start address of the array write |
| wr_data_i | input | 8 | Data byte of the status write |
| wp_level_i | input | 1 | Write-protect pin level (0 engages hardware lock) |
| prog_done_i | input | 1 | End of self-timed programming cycle pulse |
| status_o | output | 8 | Status byte for a status read |
| grant_o | output | 1 | Presented write may start |
| deny_o | output | 1 | Presented write is refused |
| busy_o | output | 1 | Programming cycle in progress |

## Verification
Assertions check the following on every cycle:
- grant and deny are exclusive and appear only alongside a write strobe;
- no write is granted without the enable latch, while busy, into a protected region, or under the hardware lock;
- the busy bit only rises after a grant;
- the protection bits stay frozen while busy;
- a done pulse clears busy and the latch.

The exact bit layout of the status byte, the loading of the data bits, and the four region boundaries are shown only by the bench's scenarios. The same goes for enable or disable strobes having no effect while busy, because these depend on concrete values compared against a bench-side model.

// File: rtl/sreg_guard_pkg.sv
// Shared types for the status-register write guard.
// Assumes an 8-bit status byte with fixed bit positions.
package sreg_guard_pkg;

    localparam int SR_W     = 8;
    localparam int LOCK_BIT = 7;
    localparam int SEL_HI   = 3;
    localparam int SEL_LO   = 2;
    localparam int WEL_BIT  = 1;
    localparam int BUSY_BIT = 0;

    typedef enum logic [1:0] {
        REGION_NONE    = 2'b00,
        REGION_QUARTER = 2'b01,
        REGION_HALF    = 2'b10,
        REGION_ALL     = 2'b11
    } region_e;

    typedef struct packed {
        logic    lock;
        region_e sel;
        logic    wel;
        logic    busy;
    } guard_state_t;

    function automatic logic [SR_W-1:0] pack_status(input guard_state_t s);
        logic [SR_W-1:0] b;
        b           = '0;
        b[LOCK_BIT] = s.lock;
        b[SEL_HI:SEL_LO] = s.sel;
        b[WEL_BIT]  = s.wel;
        b[BUSY_BIT] = s.busy;
        return b;
    endfunction

endpackage

// File: rtl/sreg_guard_region.sv
// Decides whether an address lies in the region selected by the two
// region-select bits. Assumes ADDR_W >= 2; the protected part is always
// the top of the address space.
module sreg_guard_region
    import sreg_guard_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  region_e           sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);

    localparam int TOP = ADDR_W - 1;

    // Compare the top address bits against the selected region size.
    always_comb begin
        unique case (sel_i)
            REGION_NONE:    hit_o = 1'b0;
            REGION_QUARTER: hit_o = addr_i[TOP] & addr_i[TOP-1];
            REGION_HALF:    hit_o = addr_i[TOP];
            default:        hit_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/sreg_guard_policy.sv
// Combinational grant/deny decision for array and status writes.
// Assumes at most one write strobe per cycle; the clock is used only by
// the assertions guarding the decision.
module sreg_guard_policy
    import sreg_guard_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  guard_state_t st_i,
    input  logic         cmd_wrsr_i,
    input  logic         cmd_write_i,
    input  logic         wp_level_i,
    input  logic         region_hit_i,
    output logic         grant_o,
    output logic         deny_o
);

    logic any_req;
    logic hw_locked;
    logic path_open;

    // Hardware lock: lock bit set while the protect pin is driven low.
    assign hw_locked = st_i.lock & ~wp_level_i;

    // A write may only proceed when the latch is armed and no cycle runs.
    assign path_open = st_i.wel & ~st_i.busy;

    assign any_req = cmd_wrsr_i | cmd_write_i;

    // Select the per-command protection check and form the response.
    always_comb begin
        grant_o = 1'b0;
        if (path_open) begin
            if (cmd_write_i)     grant_o = ~region_hit_i;
            else if (cmd_wrsr_i) grant_o = ~hw_locked;
        end
        deny_o = any_req & ~grant_o;
    end

    AST_RESP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && deny_o)); // R12
    AST_RESP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o || deny_o) |-> (cmd_wrsr_i || cmd_write_i)); // R12
    AST_NO_LATCH_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> st_i.wel); // R4
    AST_BUSY_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_i.busy && (cmd_wrsr_i || cmd_write_i)) |-> deny_o); // R9
    AST_REGION_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_write_i && region_hit_i) |-> !grant_o); // R5
    AST_HW_LOCK_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrsr_i && st_i.lock && !wp_level_i) |-> !grant_o); // R6

endmodule

// File: rtl/sreg_guard_state.sv
// Holds the protection state: lock bit, region select, enable latch and
// busy bit. Assumes the grant input is already qualified by the policy.
module sreg_guard_state
    import sreg_guard_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_wren_i,
    input  logic            cmd_wrdi_i,
    input  logic            cmd_wrsr_i,
    input  logic            grant_i,
    input  logic [SR_W-1:0] wr_data_i,
    input  logic            prog_done_i,
    output guard_state_t    st_o
);

    guard_state_t st_q;

    // Sequence the latch, the busy bit and status loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (st_q.busy) begin
            if (prog_done_i) begin
                st_q.busy <= 1'b0;
                st_q.wel  <= 1'b0;
            end
        end else if (grant_i) begin
            st_q.busy <= 1'b1;
            if (cmd_wrsr_i) begin
                st_q.lock <= wr_data_i[LOCK_BIT];
                st_q.sel  <= region_e'(wr_data_i[SEL_HI:SEL_LO]);
            end
        end else if (cmd_wren_i) begin
            st_q.wel <= 1'b1;
        end else if (cmd_wrdi_i) begin
            st_q.wel <= 1'b0;
        end
    end

    assign st_o = st_q;

    AST_BUSY_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !$past(st_q.busy)) |-> $past(grant_i)); // R7
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && prog_done_i) |=> (!st_q.busy && !st_q.wel)); // R8
    AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> ($stable(st_q.lock) && $stable(st_q.sel))); // R9
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && cmd_wrdi_i && !cmd_wren_i && !grant_i) |=> !st_q.wel); // R3

endmodule

// File: rtl/sreg_guard.sv
// Top of the status-register write guard: wires the region decoder, the
// grant policy and the state registers. Assumes command strobes come from
// an instruction decoder, at most one per cycle.
module sreg_guard
    import sreg_guard_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren_i,
    input  logic              cmd_wrdi_i,
    input  logic              cmd_wrsr_i,
    input  logic              cmd_write_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [SR_W-1:0]   wr_data_i,
    input  logic              wp_level_i,
    input  logic              prog_done_i,
    output logic [SR_W-1:0]   status_o,
    output logic              grant_o,
    output logic              deny_o,
    output logic              busy_o
);

    guard_state_t st;
    logic         region_hit;
    logic         grant;
    logic         unused_data;

    // Data bits outside the lock and region fields carry no meaning.
    assign unused_data = ^{wr_data_i[6:4], wr_data_i[1:0]};

    sreg_guard_region #(.ADDR_W(ADDR_W)) region_i (
        .sel_i  (st.sel),
        .addr_i (wr_addr_i),
        .hit_o  (region_hit)
    );

    sreg_guard_policy policy_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .st_i         (st),
        .cmd_wrsr_i   (cmd_wrsr_i),
        .cmd_write_i  (cmd_write_i),
        .wp_level_i   (wp_level_i),
        .region_hit_i (region_hit),
        .grant_o      (grant),
        .deny_o       (deny_o)
    );

    sreg_guard_state state_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wren_i  (cmd_wren_i),
        .cmd_wrdi_i  (cmd_wrdi_i),
        .cmd_wrsr_i  (cmd_wrsr_i),
        .grant_i     (grant),
        .wr_data_i   (wr_data_i),
        .prog_done_i (prog_done_i),
        .st_o        (st)
    );

    assign grant_o  = grant;
    assign status_o = pack_status(st);
    assign busy_o   = st.busy;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_wren_i, cmd_wrdi_i, cmd_wrsr_i, cmd_write_i})); // R12

endmodule

// File: tb/sreg_guard_tb_top.sv
module sreg_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_wrsr = 1'b0, cmd_write = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wp_level = 1'b1;
    logic        prog_done = 1'b0;
    logic [7:0]  status;
    logic        grant, deny, busy;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic       m_lock = 0, m_wel = 0, m_busy = 0;
    logic [1:0] m_sel = 0;

    always #2 clk = ~clk;

    sreg_guard dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_wren_i(cmd_wren), .cmd_wrdi_i(cmd_wrdi),
        .cmd_wrsr_i(cmd_wrsr), .cmd_write_i(cmd_write),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .wp_level_i(wp_level), .prog_done_i(prog_done),
        .status_o(status), .grant_o(grant), .deny_o(deny), .busy_o(busy)
    );

    function automatic logic exp_hit(input logic [1:0] sel, input logic [15:0] a);
        case (sel)
            2'b00:   return 1'b0;
            2'b01:   return a >= 16'hC000;
            2'b10:   return a >= 16'h8000;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] exp_status();
        return {m_lock, 3'b000, m_sel, m_wel, m_busy};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Idle cycle, then compare the status byte with a directed constant.
    task automatic peek(input string tag, input logic [7:0] exp);
        @(negedge clk);
        chk(tag, {24'd0, status}, {24'd0, exp});
    endtask

    // cmd: 0 idle, 1 enable, 2 disable, 3 status write, 4 array write
    task automatic step(input int cmd, input logic [15:0] a, input logic [7:0] d,
                        input logic wp, input logic done);
        logic  eg, req;
        string tag;
        @(negedge clk);
        chk("R2 status", {24'd0, status}, {24'd0, exp_status()});
        chk("R7 busy", {31'd0, busy}, {31'd0, m_busy});
        cmd_wren  = (cmd == 1);
        cmd_wrdi  = (cmd == 2);
        cmd_wrsr  = (cmd == 3);
        cmd_write = (cmd == 4);
        wr_addr = a; wr_data = d; wp_level = wp; prog_done = done;
        #1;
        req = (cmd == 3) || (cmd == 4);
        eg  = 1'b0;
        tag = "R12";
        if (req) begin
            if (m_busy)        tag = "R9";
            else if (!m_wel)   tag = "R4";
            else if (cmd == 4) begin tag = "R5"; eg = !exp_hit(m_sel, a); end
            else               begin tag = "R6"; eg = !(m_lock && !wp); end
        end
        chk({tag, " grant"}, {31'd0, grant}, {31'd0, eg});
        chk({tag, " deny"}, {31'd0, deny}, {31'd0, req && !eg});
        @(posedge clk);
        if (m_busy) begin
            if (done) begin m_busy = 0; m_wel = 0; end
        end else if (eg) begin
            m_busy = 1;
            if (cmd == 3) begin m_lock = d[7]; m_sel = d[3:2]; end
        end else if (cmd == 1) m_wel = 1;
        else if (cmd == 2) m_wel = 0;
        #1;
        cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_write = 0; prog_done = 0;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status", {24'd0, status}, 32'h00);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 grant/deny", {30'd0, grant, deny}, 32'd0);

        step(1, 0, 0, 1, 0);          peek("R3 enable", 8'h02);
        step(2, 0, 0, 1, 0);          peek("R3 disable", 8'h00);
        step(3, 0, 8'hFF, 1, 0);      peek("R4 unarmed status write", 8'h00);
        step(1, 0, 0, 1, 0);
        step(3, 0, 8'hFF, 1, 0);      peek("R11 load all", 8'h8F);
        step(1, 0, 0, 1, 0);
        step(4, 0, 0, 1, 0);          peek("R9 busy ignores", 8'h8F);
        step(2, 0, 0, 1, 0);          peek("R9 disable ignored", 8'h8F);
        step(0, 0, 0, 1, 1);          peek("R8 done", 8'h8C);
        step(0, 0, 0, 1, 1);          peek("R8 idle done", 8'h8C);
        step(1, 0, 0, 0, 0);
        step(3, 0, 8'h00, 0, 0);      peek("R6 hw lock", 8'h8E);
        step(3, 0, 8'h74, 1, 0);      peek("R11 other bits ignored", 8'h07);
        step(0, 0, 0, 1, 1);          peek("R8 done 2", 8'h04);
        step(1, 0, 0, 1, 0);
        step(4, 16'hC000, 0, 1, 0);   peek("R10 latch kept", 8'h06);
        step(4, 16'hBFFF, 0, 1, 0);   peek("R5 below quarter", 8'h07);
        step(0, 0, 0, 1, 1);

        for (int i = 0; i < 4000; i++) begin
            int c;
            c = int'($urandom_range(0, 4));
            step(c, 16'($urandom), 8'($urandom), 1'($urandom),
                 ($urandom_range(0, 3) == 0));
        end
        step(0, 0, 0, 1, 0);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule